// File: doc/BRIEF.md
# BCD Clock-Calendar Timekeeping Core

This block keeps the current time of day and the calendar date in packed BCD registers. It advances by one second on each cycle in which a one-pulse-per-second enable is high. An external prescaler derives that enable from a 32768 Hz reference. All carries ripple within that same cycle: seconds, minutes, hours, date, month, day-of-week and year. Month lengths and leap years are applied when the date rolls over. The hour register runs in either 12-hour or 24-hour form.

A host-side serial interface reaches every register through a flat 8-bit register port. It has a 3-bit address, a write strobe and a combinational read path. Address 7 holds a control byte whose top bit blocks writes to the timekeeping registers. Bit 7 of the seconds register halts counting.

Top module: `rtc_bcd_core`

## Requirements
- R1: After a synchronous reset the registers read: addr 0 seconds = 0x00, addr 1 minutes = 0x00, addr 2 hours = 0x00 (24-hour form), addr 3 date = 0x01, addr 4 month = 0x01, addr 5 day-of-week = 0x01, addr 6 year = 0x00, addr 7 control = 0x00.
- R2: On a tick, seconds advance by one in BCD. The step from 59 wraps to 00 and advances minutes in the same cycle. Minutes wrap the same way and advance hours.
- R3: While seconds bit 7 (halt flag) is 1, ticks change no register. Writing the bit back to 0 lets the following ticks count again.
- R4: With hours bit 7 = 0 (24-hour form), bits 5:0 hold BCD 00..23. 09 goes to 10, 19 goes to 20, and 23 goes to 00 while advancing the date.
- R5: With hours bit 7 = 1 (12-hour form), bits 4:0 hold BCD 01..12 and bit 5 is PM (1) or AM (0). 11 goes to 12 and flips bit 5. 12 goes to 01 without flipping it. 11 PM goes to 12 AM and advances the date. Bit 7 never changes on a tick.
- R6: The date wraps to 01 and advances the month after the last day. Months 04, 06, 09 and 11 end on day 30, and the other months end on day 31. February ends on day 29 when the BCD year is a multiple of four (00 included), otherwise on day 28.
- R7: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00. A full cascade from 23:59:59, 31 Dec, year 99, day-of-week 07 lands on 00:00:00, 01 Jan, year 00, day-of-week 01 in one tick.
- R8: Day-of-week advances on the same tick as the date and wraps from 07 to 01.
- R9: A register write in the same cycle as a tick stores the written value, and the tick's increment of that register is lost.
- R10: While control bit 7 (write lock) is 1, writes to addresses 0..6 are ignored. The control register itself always takes writes.
- R11: Unimplemented bits read as 0. The stored masks are: minutes 0x7F, hours 0xBF, date 0x3F, month 0x1F, day-of-week 0x07, control 0x80. Seconds and year keep all 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| reg_addr | input | 3 | Register address for read and write |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register (combinational) |

## Verification
Single ticks from ordinary values check the plain BCD digit step. Preloaded boundary values check each wrap, with the wrap from 09 to 10 kept apart from the rollovers at 59, 23 and 12. The month-end tests use years 23, 24 and 00 together with 30-day and 31-day months. They show whether the leap rule and the day-count table are applied, or only a fixed length. Writes that coincide with a tick, and writes made while locked or halted, check priority and suppression: the value read back after each one differs depending on which path won.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_SEC   = 3'd0,
        A_MIN   = 3'd1,
        A_HOUR  = 3'd2,
        A_DATE  = 3'd3,
        A_MONTH = 3'd4,
        A_DOW   = 3'd5,
        A_YEAR  = 3'd6,
        A_CTRL  = 3'd7
    } reg_addr_e;

    localparam logic [DATA_W-1:0] MASK_MIN   = 8'h7F;
    localparam logic [DATA_W-1:0] MASK_HOUR  = 8'hBF;
    localparam logic [DATA_W-1:0] MASK_DATE  = 8'h3F;
    localparam logic [DATA_W-1:0] MASK_MONTH = 8'h1F;
    localparam logic [DATA_W-1:0] MASK_DOW   = 8'h07;
    localparam logic [DATA_W-1:0] MASK_CTRL  = 8'h80;

    typedef struct packed {
        logic [DATA_W-1:0] date;
        logic [DATA_W-1:0] month;
        logic [DATA_W-1:0] dow;
        logic [DATA_W-1:0] year;
    } cal_regs_t;

    // Add one to a two-digit packed BCD value (no wrap handling).
    function automatic logic [DATA_W-1:0] bcd_inc(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'h0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    // Multiple of four: (10*t + o) mod 4 == (2*t[0] + o) mod 4.
    function automatic logic bcd_leap(input logic [DATA_W-1:0] y);
        logic [3:0] s;
        s = y[3:0] + {2'b00, y[4], 1'b0};
        return (s[1:0] == 2'b00);
    endfunction

    function automatic logic [DATA_W-1:0] month_last_day(input logic [DATA_W-1:0] m,
                                                          input logic [DATA_W-1:0] y);
        logic [DATA_W-1:0] d;
        case (m)
            8'h02:                      d = bcd_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
            default:                    d = 8'h31;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/rtc_bcd60.sv
module rtc_bcd60
    import rtc_pkg::*;
#(
    parameter bit KEEP_FLAG = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] q,
    output logic              carry_out
);
    localparam logic [DATA_W-2:0] LAST = 7'h59;

    logic [DATA_W-1:0] stepped;
    logic              at_last;

    always_comb begin
        at_last = (q[DATA_W-2:0] >= LAST);
        stepped = bcd_inc({1'b0, q[DATA_W-2:0]});
        if (at_last) stepped = '0;
        stepped[DATA_W-1] = q[DATA_W-1];
    end

    assign carry_out = inc_en && at_last;

    always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (wr_en)   q <= KEEP_FLAG ? wr_data : {1'b0, wr_data[DATA_W-2:0]};
        else if (inc_en)  q <= stepped;
    end

    // R2: a tick from a value below 59 moves up without carrying
    assert_no_early_carry_R2: assert property (@(posedge clk) disable iff (rst)
        (inc_en && !wr_en && q[6:0] < 7'h59 && q[3:0] != 4'h9) |=> (q[3:0] == $past(q[3:0]) + 4'd1));
endmodule

// File: rtl/rtc_hour.sv
module rtc_hour
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inc_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] q,
    output logic              carry_out
);
    logic [DATA_W-1:0] nxt;
    logic [DATA_W-1:0] hr;
    logic [DATA_W-1:0] hr_inc;
    logic              wrap;
    logic              pm;

    always_comb begin
        pm   = q[5];
        wrap = 1'b0;
        if (q[7]) begin
            hr     = {3'b000, q[4:0]};
            hr_inc = bcd_inc(hr);
            if (hr == 8'h11) begin
                nxt  = {1'b1, 1'b0, ~pm, 5'h12};
                wrap = pm;
            end else if (hr >= 8'h12) begin
                nxt  = {1'b1, 1'b0, pm, 5'h01};
            end else begin
                nxt  = {1'b1, 1'b0, pm, hr_inc[4:0]};
            end
        end else begin
            hr     = {2'b00, q[5:0]};
            hr_inc = bcd_inc(hr);
            if (hr >= 8'h23) begin
                nxt  = '0;
                wrap = 1'b1;
            end else begin
                nxt  = {2'b00, hr_inc[5:0]};
            end
        end
    end

    assign carry_out = inc_en && wrap;

    always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (wr_en)  q <= wr_data & MASK_HOUR;
        else if (inc_en) q <= nxt;
    end

    // R5: the format bit survives every increment
    assert_mode_kept_R5: assert property (@(posedge clk) disable iff (rst)
        (inc_en && !wr_en) |=> (q[7] == $past(q[7])));
    // R5: 12 o'clock goes to 01 with the AM/PM flag unchanged
    assert_twelve_to_one_R5: assert property (@(posedge clk) disable iff (rst)
        (inc_en && !wr_en && q[7] && q[4:0] == 5'h12) |=> (q[4:0] == 5'h01 && q[5] == $past(q[5])));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              day_adv,
    input  logic [3:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output cal_regs_t         cal
);
    logic [DATA_W-1:0] last_day;
    logic              date_wrap, month_wrap;
    logic              month_adv, year_adv;
    cal_regs_t         nxt;

    always_comb begin
        last_day   = month_last_day(cal.month, cal.year);
        date_wrap  = (cal.date >= last_day);
        month_wrap = (cal.month >= 8'h12);
        month_adv  = day_adv && date_wrap;
        year_adv   = month_adv && month_wrap;

        nxt       = cal;
        nxt.date  = date_wrap  ? 8'h01 : bcd_inc(cal.date);
        nxt.month = month_wrap ? 8'h01 : bcd_inc(cal.month);
        nxt.dow   = (cal.dow >= 8'h07) ? 8'h01 : (cal.dow + 8'h01);
        nxt.year  = (cal.year >= 8'h99) ? 8'h00 : bcd_inc(cal.year);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cal.date  <= 8'h01;
            cal.month <= 8'h01;
            cal.dow   <= 8'h01;
            cal.year  <= 8'h00;
        end else begin
            if (wr_sel[0])      cal.date <= wr_data & MASK_DATE;
            else if (day_adv)   cal.date <= nxt.date;

            if (wr_sel[1])      cal.month <= wr_data & MASK_MONTH;
            else if (month_adv) cal.month <= nxt.month;

            if (wr_sel[2])      cal.dow <= wr_data & MASK_DOW;
            else if (day_adv)   cal.dow <= nxt.dow;

            if (wr_sel[3])      cal.year <= wr_data;
            else if (year_adv)  cal.year <= nxt.year;
        end
    end

    // R8: day-of-week wraps 07 -> 01 on a day advance
    assert_dow_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (day_adv && !wr_sel[2] && cal.dow == 8'h07) |=> (cal.dow == 8'h01));
    // R6: the date never steps beyond the month's last day
    assert_date_bound_R6: assert property (@(posedge clk) disable iff (rst)
        (day_adv && wr_sel == 4'b0000 && cal.date == 8'h28 && cal.month == 8'h02 && cal.year == 8'h23)
        |=> (cal.date == 8'h01 && cal.month == 8'h03));
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int N_MS = 2;

    logic [DATA_W-1:0] ms_q   [N_MS];
    logic              ms_inc [N_MS];
    logic              ms_cy  [N_MS];
    logic [DATA_W-1:0] hour_q;
    logic              hour_cy;
    cal_regs_t         cal;
    logic [DATA_W-1:0] ctrl_q;
    logic              wr_ok;
    logic [7:0]        wr_dec;
    logic              run_tick;

    assign wr_ok    = reg_we && (!ctrl_q[7] || reg_addr == A_CTRL);
    assign run_tick = sec_tick && !ms_q[0][7];

    always_comb begin
        wr_dec = '0;
        wr_dec[reg_addr] = wr_ok;
    end

    // Seconds (index 0, keeps halt flag) and minutes (index 1)
    genvar gi;
    generate
        for (gi = 0; gi < N_MS; gi++) begin : g_ms
            if (gi == 0) begin : g_in
                assign ms_inc[gi] = run_tick;
            end else begin : g_in
                assign ms_inc[gi] = ms_cy[gi-1];
            end
            rtc_bcd60 #(.KEEP_FLAG(gi == 0)) u_cnt (
                .clk       (clk),
                .rst       (rst),
                .inc_en    (ms_inc[gi]),
                .wr_en     (wr_dec[gi]),
                .wr_data   (reg_wdata),
                .q         (ms_q[gi]),
                .carry_out (ms_cy[gi])
            );
        end
    endgenerate

    rtc_hour u_hour (
        .clk       (clk),
        .rst       (rst),
        .inc_en    (ms_cy[N_MS-1]),
        .wr_en     (wr_dec[A_HOUR]),
        .wr_data   (reg_wdata),
        .q         (hour_q),
        .carry_out (hour_cy)
    );

    rtc_calendar u_cal (
        .clk     (clk),
        .rst     (rst),
        .day_adv (hour_cy),
        .wr_sel  (wr_dec[A_YEAR:A_DATE]),
        .wr_data (reg_wdata),
        .cal     (cal)
    );

    always_ff @(posedge clk) begin
        if (rst)              ctrl_q <= '0;
        else if (wr_dec[A_CTRL]) ctrl_q <= reg_wdata & MASK_CTRL;
    end

    always_comb begin
        case (reg_addr)
            A_SEC:   reg_rdata = ms_q[0];
            A_MIN:   reg_rdata = ms_q[1];
            A_HOUR:  reg_rdata = hour_q;
            A_DATE:  reg_rdata = cal.date;
            A_MONTH: reg_rdata = cal.month;
            A_DOW:   reg_rdata = cal.dow;
            A_YEAR:  reg_rdata = cal.year;
            default: reg_rdata = ctrl_q;
        endcase
    end

    // R3: with the halt flag set and no write, nothing moves
    assert_halt_freeze_R3: assert property (@(posedge clk) disable iff (rst)
        (ms_q[0][7] && !reg_we) |=> ($stable(ms_q[0]) && $stable(ms_q[1]) && $stable(hour_q) && $stable(cal)));
    // R10: a locked write to seconds without a tick leaves seconds unchanged
    assert_lock_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[7] && reg_we && reg_addr == A_SEC && !sec_tick) |=> $stable(ms_q[0]));
    // R9: an accepted minutes write wins over any carry
    assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q[7] && reg_we && reg_addr == A_MIN) |=> (ms_q[1] == ($past(reg_wdata) & MASK_MIN)));
endmodule

// File: tb/rtc_bcd_core_tb_top.sv
module rtc_bcd_core_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rtc_bcd_core dut_i (
        .clk(clk), .rst(rst), .sec_tick(sec_tick),
        .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input logic [2:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        n_cmp++;
        if (reg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s addr %0d: got %02h expected %02h", req, a, reg_rdata, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic set_all(input logic [7:0] s, m, h, dt, mo, dw, y);
        wr(0, s); wr(1, m); wr(2, h); wr(3, dt); wr(4, mo); wr(5, dw); wr(6, y);
    endtask

    task automatic t_reset();
        check("R1", 0, 8'h00); check("R1", 1, 8'h00); check("R1", 2, 8'h00);
        check("R1", 3, 8'h01); check("R1", 4, 8'h01); check("R1", 5, 8'h01);
        check("R1", 6, 8'h00); check("R1", 7, 8'h00);
    endtask

    task automatic t_seconds();
        wr(0, 8'h08); tick(); check("R2", 0, 8'h09);
        tick(); check("R2", 0, 8'h10);
        wr(0, 8'h59); wr(1, 8'h09); tick();
        check("R2", 0, 8'h00); check("R2", 1, 8'h10);
        wr(0, 8'h59); wr(1, 8'h59); wr(2, 8'h05); tick();
        check("R2", 1, 8'h00); check("R2", 2, 8'h06);
    endtask

    task automatic t_halt();
        wr(0, 8'hD9); wr(1, 8'h12); tick(); tick();
        check("R3", 0, 8'hD9); check("R3", 1, 8'h12);
        wr(0, 8'h05); tick(); check("R3", 0, 8'h06);
    endtask

    task automatic t_hour24();
        wr(0, 8'h59); wr(1, 8'h59); wr(2, 8'h09); tick(); check("R4", 2, 8'h10);
        wr(0, 8'h59); wr(1, 8'h59); wr(2, 8'h19); tick(); check("R4", 2, 8'h20);
    endtask

    task automatic t_hour12();
        set_all(8'h59, 8'h59, 8'h91, 8'h10, 8'h05, 8'h03, 8'h20);
        tick(); check("R5", 2, 8'hB2); check("R5", 3, 8'h10);
        wr(0, 8'h59); wr(1, 8'h59); tick(); check("R5", 2, 8'hA1);
        wr(0, 8'h59); wr(1, 8'h59); wr(2, 8'hB1); tick();
        check("R5", 2, 8'h92); check("R5", 3, 8'h11); check("R8", 5, 8'h04);
    endtask

    task automatic t_month_end(input logic [7:0] dt, mo, y, exp_dt, exp_mo);
        set_all(8'h59, 8'h59, 8'h23, dt, mo, 8'h02, y);
        tick(); check("R6", 3, exp_dt); check("R6", 4, exp_mo);
    endtask

    task automatic t_cascade();
        set_all(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h07, 8'h99);
        tick();
        check("R7", 0, 8'h00); check("R7", 1, 8'h00); check("R7", 2, 8'h00);
        check("R7", 3, 8'h01); check("R7", 4, 8'h01); check("R8", 5, 8'h01);
        check("R7", 6, 8'h00);
    endtask

    task automatic t_priority();
        wr(0, 8'h59); wr(1, 8'h10);
        @(negedge clk);
        sec_tick = 1'b1; reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h33;
        @(negedge clk);
        sec_tick = 1'b0; reg_we = 1'b0;
        check("R9", 0, 8'h00); check("R9", 1, 8'h33);
        @(negedge clk);
        sec_tick = 1'b1; reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h20;
        @(negedge clk);
        sec_tick = 1'b0; reg_we = 1'b0;
        check("R9", 0, 8'h20);
    endtask

    task automatic t_lock();
        wr(0, 8'h15); wr(7, 8'hFF); check("R10", 7, 8'h80);
        wr(0, 8'h30); wr(6, 8'h77); check("R10", 0, 8'h15); check("R10", 6, 8'h00);
        wr(7, 8'h00); wr(0, 8'h30); check("R10", 0, 8'h30);
    endtask

    task automatic t_masks();
        wr(1, 8'hFF); check("R11", 1, 8'h7F);
        wr(4, 8'hE5); check("R11", 4, 8'h05);
        wr(5, 8'hFB); check("R11", 5, 8'h03);
        wr(3, 8'hD2); check("R11", 3, 8'h12);
        wr(2, 8'hF2); check("R11", 2, 8'hB2);
    endtask

    initial begin : watchdog
        #1000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_seconds();
        t_halt();
        t_hour24();
        t_hour12();
        t_month_end(8'h28, 8'h02, 8'h24, 8'h29, 8'h02);
        t_month_end(8'h29, 8'h02, 8'h24, 8'h01, 8'h03);
        t_month_end(8'h28, 8'h02, 8'h23, 8'h01, 8'h03);
        t_month_end(8'h28, 8'h02, 8'h00, 8'h29, 8'h02);
        t_month_end(8'h30, 8'h04, 8'h23, 8'h01, 8'h05);
        t_month_end(8'h30, 8'h01, 8'h23, 8'h31, 8'h01);
        t_month_end(8'h31, 8'h01, 8'h23, 8'h01, 8'h02);
        t_cascade();
        t_priority();
        t_lock();
        t_masks();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule